// File: doc/BRIEF.md
# FFT Block-Load Input Controller

This block sits in front of the workspace memory of a block FFT engine and decides which incoming samples are written, where they go, and when the engine may start a transform. Samples arrive as single-cycle strobes that are synchronous to the system clock. The strobe may run without pause, because the controller only turns a strobe into a memory write while a load is enabled. The controller produces a write enable and a write address for the sample memory, a flag that is high while a load is in progress, and a one-cycle start pulse for the FFT core.

The controller has two loading styles, chosen by `levelMode`. In the gated style, the active-low `loadEnN` is sampled on every strobe, so a high level skips over gaps in the data. In the triggered style, a falling edge on `loadEnN` starts a load that runs until its sample count is reached, whatever `loadEnN` does after that. With blocks of 256 points or fewer, the overlap code lets a transform start after one half or one quarter of a fresh block, and the rest of the block is the older samples already held in memory. At the 1024-point length the controller stops taking samples after a full block and waits for the core to report that the results have been dumped.

The length and overlap codes are expected to stay stable while a load is in progress.

Top module: `fft_load_ctrl`

## Requirements
- R1: A memory write (`memWrEn` high for one cycle, one clock after the strobe edge) happens only for a strobe that arrives while loading is enabled. All other strobes are dropped.
- R2: With `levelMode`=1, a strobe is accepted exactly when `loadEnN` is 0 in the same cycle. Holding `loadEnN` at 0 loads every strobe.
- R3: With `levelMode`=0, a cycle in which `loadEnN` goes from 1 to 0 starts a load, and a strobe in that same cycle is already accepted. The load then accepts every strobe until its count is reached, even if `loadEnN` returns to 1.
- R4: With `levelMode`=0, a falling edge of `loadEnN` during a load, or while waiting for a dump, is ignored. Only a new 1-to-0 transition after completion starts the next load.
- R5: The count for one load is the block length for overlap code 0 or 3, half the length for code 1 (50%), and a quarter of the length for code 2 (75%). `xformStart` pulses for one cycle, on the write of the last sample of that count.
- R6: The block-length code maps 0→64, 1→128, 2→256 and 3→1024 points. For the 1024-point length the overlap code is ignored and the count is the full block.
- R7: At length code 3, once 1024 samples have been written, no strobe is accepted in either mode until `dumpAck` has been seen high for a clock. Strobes start being accepted again the cycle after that.
- R8: `loadActive` rises together with the write of the first sample of a load and falls together with the write of the last one. It stays high across gaps in gated mode.
- R9: `memWrAddr` starts at 0 after reset and advances by one per accepted sample, modulo the block length. It does not restart at a load boundary, so overlapped loads overwrite the oldest samples.
- R10: `xformStart` arrives in the same cycle as the final write of a load, well within 12 clocks of it.
- R11: Reset clears the count, the address, `loadActive` and the edge history. A `loadEnN` that is already 0 when reset is released is not taken as a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One-cycle sample-present strobe |
| loadEnN | input | 1 | Active-low load enable, used as a gate or as a start edge |
| levelMode | input | 1 | 1 = gated loading, 0 = edge-started loading |
| lenCode | input | 2 | Block length: 0=64, 1=128, 2=256, 3=1024 |
| ovlCode | input | 2 | Overlap: 0 none, 1 50%, 2 75%, 3 none |
| dumpAck | input | 1 | Core reports that the previous results have been dumped |
| memWrEn | output | 1 | Sample memory write enable |
| memWrAddr | output | 10 | Sample memory write address |
| loadActive | output | 1 | High while a load is in progress |
| xformStart | output | 1 | One-cycle transform start pulse |

## Verification
A wrong sample count shows at the ports within one block: `xformStart` and the fall of `loadActive` move away from the write that should end the load. A lost or stuck edge-mode run flag shows as writes that happen, or are missing, on the first strobe after a `loadEnN` edge. A wrong address pointer shows on the very next `memWrEn`. Each of these errors surfaces within one block length of strobes, and most on the next clock.

// File: rtl/fft_load_pkg.sv
package fft_load_pkg;

  // Control-to-datapath strobes for one clock cycle.
  typedef struct packed {
    logic wr;     // accept the current sample
    logic last;   // this sample completes the load count
  } ctlStrb_t;

  typedef enum logic [1:0] {
    OVL_NONE = 2'd0,
    OVL_HALF = 2'd1,
    OVL_QTR  = 2'd2,
    OVL_ALT  = 2'd3
  } ovlSel_t;

endpackage

// File: rtl/fft_load_cfg.sv
module fft_load_cfg #(
  parameter int MIN_LOG2 = 6,
  parameter int MAX_LOG2 = 10,
  parameter int OVL_MAX_LOG2 = 8,
  localparam int ADDR_W = MAX_LOG2,
  localparam int LOG_W = $clog2(MAX_LOG2 + 1)
) (
  input  logic [1:0]        lenCode,
  input  logic [1:0]        ovlCode,
  output logic [ADDR_W-1:0] blkMask,
  output logic [ADDR_W-1:0] stepLast,
  output logic              isLongest
);
  import fft_load_pkg::*;

  logic [LOG_W-1:0] lenLog2;
  logic [ADDR_W:0]  fullLen;
  logic [ADDR_W:0]  stepLen;
  logic [1:0]       shiftAmt;
  logic             ovlOk;
  ovlSel_t          ovlSel;

  always_comb begin
    ovlSel    = ovlSel_t'(ovlCode);
    isLongest = (lenCode == 2'd3);
    lenLog2   = isLongest ? LOG_W'(MAX_LOG2) : (LOG_W'(MIN_LOG2) + LOG_W'(lenCode));
    fullLen   = (ADDR_W + 1)'(1) << lenLog2;
    ovlOk     = (lenLog2 <= LOG_W'(OVL_MAX_LOG2));
    unique case (ovlSel)
      OVL_HALF: shiftAmt = ovlOk ? 2'd1 : 2'd0;
      OVL_QTR:  shiftAmt = ovlOk ? 2'd2 : 2'd0;
      default:  shiftAmt = 2'd0;
    endcase
    stepLen  = fullLen >> shiftAmt;
    blkMask  = ADDR_W'(fullLen - (ADDR_W + 1)'(1));
    stepLast = ADDR_W'(stepLen - (ADDR_W + 1)'(1));
  end

endmodule

// File: rtl/fft_load_seq.sv
module fft_load_seq
  import fft_load_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleStrobe,
  input  logic     loadEnN,
  input  logic     levelMode,
  input  logic     dumpAck,
  input  logic     isLongest,
  input  logic     lastHit,
  output ctlStrb_t strb,
  output logic     waitDump,
  output logic     loadActive,
  output logic     xformStart
);

  logic prevEnN;
  logic running;
  logic fallSeen;
  logic startNow;
  logic gateOpen;
  logic accept;
  logic complete;

  always_comb begin
    fallSeen = prevEnN & ~loadEnN;
    startNow = ~levelMode & fallSeen & ~running & ~waitDump;
    gateOpen = levelMode ? ~loadEnN : (running | startNow);
    accept   = sampleStrobe & gateOpen & ~waitDump;
    complete = accept & lastHit;
    strb.wr   = accept;
    strb.last = complete;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEnN    <= 1'b0;
      running    <= 1'b0;
      waitDump   <= 1'b0;
      loadActive <= 1'b0;
      xformStart <= 1'b0;
    end else begin
      prevEnN    <= loadEnN;
      xformStart <= complete;
      if (complete) running <= 1'b0;
      else if (startNow) running <= 1'b1;
      if (complete && isLongest) waitDump <= 1'b1;
      else if (dumpAck) waitDump <= 1'b0;
      if (accept) loadActive <= ~complete;
    end
  end

  AST_EDGE_NO_GATE: assert property (@(posedge clk) disable iff (!rstN)
    running && !levelMode && sampleStrobe && !waitDump |=> loadActive || xformStart); // R3

  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    xformStart && isLongest |-> waitDump); // R7

endmodule

// File: rtl/fft_load_path.sv
module fft_load_path
  import fft_load_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] blkMask,
  input  logic [ADDR_W-1:0] stepLast,
  output logic              lastHit,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr
);

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] sampleCnt;

  assign lastHit = (sampleCnt == stepLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      sampleCnt <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
    end else begin
      memWrEn <= strb.wr;
      if (strb.wr) begin
        memWrAddr <= wrPtr & blkMask;
        wrPtr     <= (wrPtr + 1'b1) & blkMask;
        sampleCnt <= strb.last ? '0 : sampleCnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= stepLast); // R5

  AST_PTR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr & ~blkMask) == '0); // R9

endmodule

// File: rtl/fft_load_ctrl.sv
module fft_load_ctrl
  import fft_load_pkg::*;
#(
  parameter int MIN_LOG2 = 6,
  parameter int MAX_LOG2 = 10,
  parameter int OVL_MAX_LOG2 = 8,
  localparam int ADDR_W = MAX_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStrobe,
  input  logic              loadEnN,
  input  logic              levelMode,
  input  logic [1:0]        lenCode,
  input  logic [1:0]        ovlCode,
  input  logic              dumpAck,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic              loadActive,
  output logic              xformStart
);

  logic [ADDR_W-1:0] blkMask;
  logic [ADDR_W-1:0] stepLast;
  logic              isLongest;
  logic              lastHit;
  logic              waitDump;
  ctlStrb_t          strb;

  fft_load_cfg #(
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .OVL_MAX_LOG2(OVL_MAX_LOG2)
  ) uCfg (
    .lenCode(lenCode), .ovlCode(ovlCode),
    .blkMask(blkMask), .stepLast(stepLast), .isLongest(isLongest)
  );

  fft_load_seq uSeq (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .loadEnN(loadEnN),
    .levelMode(levelMode), .dumpAck(dumpAck), .isLongest(isLongest),
    .lastHit(lastHit), .strb(strb), .waitDump(waitDump),
    .loadActive(loadActive), .xformStart(xformStart)
  );

  fft_load_path #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .blkMask(blkMask),
    .stepLast(stepLast), .lastHit(lastHit),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr)
  );

  AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(sampleStrobe)); // R1

  AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && $past(levelMode) |-> !$past(loadEnN)); // R2

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrAddr & ~$past(blkMask)) == '0); // R9

  AST_START_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    xformStart |-> memWrEn); // R10

  AST_ACTIVE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    xformStart |-> !loadActive); // R8

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    waitDump |=> !memWrEn); // R7

endmodule

// File: tb/fft_load_ctrl_test.sv
module fft_load_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleStrobe = 1'b0;
  logic       loadEnN = 1'b1;
  logic       levelMode = 1'b0;
  logic [1:0] lenCode = 2'd0;
  logic [1:0] ovlCode = 2'd0;
  logic       dumpAck = 1'b0;
  logic       memWrEn;
  logic [9:0] memWrAddr;
  logic       loadActive;
  logic       xformStart;

  fft_load_ctrl uut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .loadEnN(loadEnN),
    .levelMode(levelMode), .lenCode(lenCode), .ovlCode(ovlCode),
    .dumpAck(dumpAck), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .loadActive(loadActive), .xformStart(xformStart)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int wrSeen = 0;
  int startSeen = 0;
  int cyc = 0;

  // Reference model state
  int  mCnt = 0, mPtr = 0;
  bit  mRun = 0, mWait = 0, mPrev = 0;
  bit  eWr = 0, eAct = 0, eStart = 0;
  int  eAddr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic modelStep();
    int n, s;
    bit fall, start, en, acc;
    if (!rstN) begin
      mCnt = 0; mPtr = 0; mRun = 0; mWait = 0; mPrev = 0;
      eWr = 0; eAct = 0; eStart = 0; eAddr = 0;
      return;
    end
    n = (lenCode == 2'd3) ? 1024 : (64 << lenCode);
    s = n;
    if (n <= 256 && ovlCode == 2'd1) s = n / 2;
    if (n <= 256 && ovlCode == 2'd2) s = n / 4;
    fall = mPrev && !loadEnN;
    mPrev = loadEnN;
    start = !levelMode && fall && !mRun && !mWait;
    if (start) mRun = 1;
    en = levelMode ? !loadEnN : mRun;
    acc = sampleStrobe && en && !mWait;
    eWr = acc;
    eStart = 0;
    if (acc) begin
      eAddr = mPtr;
      mPtr = (mPtr + 1) % n;
      mCnt++;
      eAct = 1;
      if (mCnt == s) begin
        mCnt = 0; mRun = 0; eAct = 0; eStart = 1;
        if (n == 1024) mWait = 1;
      end
    end
    if (!(eStart && n == 1024) && dumpAck) mWait = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD / 4);
    cyc++;
    modelStep();
    check(memWrEn == eWr, "R1 memWrEn", int'(memWrEn), int'(eWr));
    if (eWr) check(memWrAddr == 10'(eAddr), "R9 memWrAddr", int'(memWrAddr), eAddr);
    check(loadActive == eAct, "R8 loadActive", int'(loadActive), int'(eAct));
    check(xformStart == eStart, "R5 xformStart", int'(xformStart), int'(eStart));
    if (xformStart) check(memWrEn == 1'b1, "R10 start with last write", int'(memWrEn), 1);
    if (memWrEn) wrSeen++;
    if (xformStart) startSeen++;
  endtask

  task automatic doReset(input bit lvl, input logic [1:0] len, input logic [1:0] ovl, input bit en);
    rstN = 1'b0; levelMode = lvl; lenCode = len; ovlCode = ovl; loadEnN = en;
    sampleStrobe = 1'b0; dumpAck = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    wrSeen = 0; startSeen = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state, then a low loadEnN at release is not a start edge
    doReset(1'b0, 2'd0, 2'd0, 1'b0);
    check(memWrEn == 0 && loadActive == 0 && xformStart == 0, "R11 reset outputs", int'(memWrEn), 0);
    sampleStrobe = 1'b1;
    for (int i = 0; i < 20; i++) tick();
    check(wrSeen == 0, "R11 no start from held-low enable", wrSeen, 0);

    // R3/R4: edge start, enable bounces and an early edge mid-load
    loadEnN = 1'b1; tick(); tick();
    loadEnN = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (i == 5) loadEnN = 1'b1;
      if (i == 10) loadEnN = 1'b0;
      tick();
    end
    check(wrSeen == 64, "R3 edge load runs to full count", wrSeen, 64);
    check(startSeen == 1, "R4 early edge ignored", startSeen, 1);
    loadEnN = 1'b1; tick(); loadEnN = 1'b0;
    for (int i = 0; i < 80; i++) tick();
    check(wrSeen == 128, "R4 new edge after completion loads again", wrSeen, 128);

    // R2/R5: gated mode, 128 points, 50% overlap, gaps and sparse strobes
    doReset(1'b1, 2'd1, 2'd1, 1'b1);
    for (int i = 0; i < 600; i++) begin
      sampleStrobe = (i % 3) != 0;
      loadEnN = ((i / 7) % 4) == 3;
      tick();
    end
    check(startSeen == wrSeen / 64, "R5 50% overlap start every half block", startSeen, wrSeen / 64);
    check(wrSeen > 200, "R2 gated loading progresses", wrSeen, 201);

    // R5: 256 points, 75% overlap, continuous
    doReset(1'b1, 2'd2, 2'd2, 1'b0);
    sampleStrobe = 1'b1;
    for (int i = 0; i < 300; i++) tick();
    check(startSeen == wrSeen / 64, "R5 75% overlap start every quarter", startSeen, wrSeen / 64);

    // R6/R7: 1024 points ignore overlap and stall until dump
    doReset(1'b1, 2'd3, 2'd2, 1'b0);
    sampleStrobe = 1'b1;
    for (int i = 0; i < 1100; i++) tick();
    check(wrSeen == 1024, "R7 stops after 1024 samples", wrSeen, 1024);
    check(startSeen == 1, "R6 overlap ignored at 1024", startSeen, 1);
    dumpAck = 1'b1; tick(); dumpAck = 1'b0;
    for (int i = 0; i < 10; i++) tick();
    check(wrSeen > 1024, "R7 resumes after dump", wrSeen, 1025);

    // R7 in edge mode: edge during the stall is ignored
    doReset(1'b0, 2'd3, 2'd0, 1'b1);
    sampleStrobe = 1'b1; tick(); loadEnN = 1'b0;
    for (int i = 0; i < 1040; i++) tick();
    loadEnN = 1'b1; tick(); loadEnN = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    check(wrSeen == 1024, "R7 edge ignored while waiting for dump", wrSeen, 1024);

    // R5: 256 points, overlap code 3 treated as none, edge mode
    doReset(1'b0, 2'd2, 2'd3, 1'b1);
    sampleStrobe = 1'b1; tick(); loadEnN = 1'b0;
    for (int i = 0; i < 300; i++) tick();
    check(wrSeen == 256 && startSeen == 1, "R5 code 3 means full block", wrSeen, 256);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule